// File: doc/BRIEF.md
# Hierarchical Error Injection Trigger

This block turns a software or hardware "insert an error now" request into exactly one single-cycle insertion pulse per enabled error type, for every transmit block of every port in a multi-port device. Each block picks its trigger through a three-level cascade. At the bottom, a block-level route bit chooses between the block's own request bit and whatever its port resolves to. In the middle, a port-level route bit chooses between the port's own request bit and the device-wide result. At the top, a global route bit chooses between a global request bit and an asynchronous external pin. The pin passes through a two-flop synchronizer.

Every block watches its selected trigger for a 0-to-1 change. Such a change arms a pending request. The request is spent at the block's next insertion opportunity, which is marked by a strobe from the datapath. While that strobe is high, the block drives one pulse on each error type whose enable bit is set. Any number of rising edges between two opportunities still produces a single insertion. The datapath corruption itself lies outside this block.

Top module: `err_inject_trig`

## Requirements
- R1: After reset no request is pending, so an opportunity strobe with all types enabled yields no insertion pulse.
- R2: With the block route bit at 0, the block's own request bit is the trigger, and changes on the port bit, global bit and external pin have no effect on that block.
- R3: With the block route bit at 1 and its port's route bit at 0, the port request bit is the trigger, and the block's own bit and the global bit are ignored.
- R4: With the block and port route bits at 1 and the global route bit at 0, the global request bit is the trigger, and the port request bit is ignored.
- R5: With the global route bit at 1, the external pin is the trigger, seen through two synchronizing flops. Suppose the pin rises before clock edge A. An opportunity in the cycle after edge A+1 yields no pulse, and an opportunity in the cycle after edge A+2 yields a pulse.
- R6: Several rising edges of the trigger between two opportunities produce exactly one insertion. The following opportunity yields nothing.
- R7: Pulses appear only on enabled types. Block k = port*N_BLK + blk owns the enable and pulse bits k*N_TYPE+t, for type t.
- R8: An insertion pulse is high only while the block's opportunity strobe is high, in the same cycle (combinational from the strobe), and lasts one cycle per request.
- R9: An opportunity spends a pending request even when no type is enabled. Enabling types afterwards does not bring the request back.
- R10: A rising edge in the same cycle as the opportunity that spends a request re-arms it, so the next opportunity inserts again.
- R11: A trigger held high does not re-arm the block. Only a 0-to-1 change arms it.
- R12: Blocks are independent. An opportunity on one block neither fires nor clears another block's pending request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ext_trig_pin | input | 1 | Asynchronous external trigger pin |
| glb_use_pin | input | 1 | Global route: 1 selects the pin, 0 selects glb_reg_trig |
| glb_reg_trig | input | 1 | Global request bit |
| port_use_glb | input | N_PORT | Per-port route: 1 passes on the global result |
| port_reg_trig | input | N_PORT | Per-port request bits |
| blk_use_port | input | N_PORT*N_BLK | Per-block route: 1 takes the port result |
| blk_reg_trig | input | N_PORT*N_BLK | Per-block request bits |
| blk_type_en | input | N_PORT*N_BLK*N_TYPE | Per-block, per-type enable bits |
| blk_opp | input | N_PORT*N_BLK | Per-block insertion opportunity strobe |
| ins_pulse | output | N_PORT*N_BLK*N_TYPE | Per-block, per-type insertion pulses |

## Verification
A block's trigger can rise in the very cycle in which its opportunity strobe spends the pending request. The arm and clear actions then meet in one register update. The bench provokes this by lowering a block's request bit after arming it, then raising it again together with the opportunity strobe. The bench passes this case only if two pulses follow: one in that cycle and one at the next opportunity. Holding the bit high afterwards must yield no third pulse.

// File: rtl/eit_pkg.sv
package eit_pkg;

  // One stage of the routing cascade: take the upstream result or the local bit.
  function automatic logic pick_src(input logic use_up, input logic own_bit,
                                    input logic up_res);
    return use_up ? up_res : own_bit;
  endfunction

  // Zero-to-one detection against the previous sample.
  function automatic logic rise_of(input logic cur, input logic prev);
    return cur & ~prev;
  endfunction

  // Pending-request update: a new rise wins over consumption.
  function automatic logic next_armed(input logic rise, input logic fire,
                                      input logic armed);
    if (rise)      return 1'b1;
    else if (fire) return 1'b0;
    else           return armed;
  endfunction

endpackage

// File: rtl/eit_sync.sv
module eit_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] sh;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (!rst_n) sh <= '0;
        else        sh <= d;
      end
    end else begin : g_many
      always_ff @(posedge clk) begin
        if (!rst_n) sh <= '0;
        else        sh <= {sh[STAGES-2:0], d};
      end
    end
  endgenerate

  assign q = sh[STAGES-1];
endmodule

// File: rtl/eit_sel.sv
module eit_sel
  import eit_pkg::*;
(
  input  logic use_up,
  input  logic own_bit,
  input  logic up_res,
  output logic res
);
  assign res = pick_src(use_up, own_bit, up_res);
endmodule

// File: rtl/eit_arm.sv
module eit_arm
  import eit_pkg::*;
#(
  parameter int N_TYPE = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              trig,
  input  logic              opp,
  input  logic [N_TYPE-1:0] type_en,
  output logic [N_TYPE-1:0] ins,
  output logic              armed_q,
  output logic              rise,
  output logic              fire
);
  logic prev_q;

  assign rise = rise_of(trig, prev_q);
  assign fire = opp & armed_q;
  assign ins  = {N_TYPE{fire}} & type_en;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev_q  <= 1'b0;
      armed_q <= 1'b0;
    end else begin
      prev_q  <= trig;
      armed_q <= next_armed(rise, fire, armed_q);
    end
  end
endmodule

// File: rtl/err_inject_trig.sv
module err_inject_trig #(
  parameter int N_PORT      = 2,
  parameter int N_BLK       = 3,
  parameter int N_TYPE      = 4,
  parameter int SYNC_STAGES = 2,
  localparam int NB = N_PORT * N_BLK,
  localparam int NI = NB * N_TYPE
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ext_trig_pin,
  input  logic          glb_use_pin,
  input  logic          glb_reg_trig,
  input  logic [N_PORT-1:0] port_use_glb,
  input  logic [N_PORT-1:0] port_reg_trig,
  input  logic [NB-1:0] blk_use_port,
  input  logic [NB-1:0] blk_reg_trig,
  input  logic [NI-1:0] blk_type_en,
  input  logic [NB-1:0] blk_opp,
  output logic [NI-1:0] ins_pulse
);
  // Named internal events, brought out for the bound checker.
  logic              pin_sync;
  logic              glb_res;
  logic [N_PORT-1:0] port_res;
  logic [NB-1:0]     blk_trig;
  logic [NB-1:0]     armed_vec;
  logic [NB-1:0]     rise_vec;
  logic [NB-1:0]     fire_vec;

  eit_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(ext_trig_pin), .q(pin_sync)
  );

  eit_sel u_glb (
    .use_up(glb_use_pin), .own_bit(glb_reg_trig), .up_res(pin_sync), .res(glb_res)
  );

  genvar p, b;
  generate
    for (p = 0; p < N_PORT; p++) begin : g_port
      eit_sel u_port (
        .use_up(port_use_glb[p]), .own_bit(port_reg_trig[p]),
        .up_res(glb_res), .res(port_res[p])
      );
      for (b = 0; b < N_BLK; b++) begin : g_blk
        localparam int K = p * N_BLK + b;
        eit_sel u_bsel (
          .use_up(blk_use_port[K]), .own_bit(blk_reg_trig[K]),
          .up_res(port_res[p]), .res(blk_trig[K])
        );
        eit_arm #(.N_TYPE(N_TYPE)) u_arm (
          .clk(clk), .rst_n(rst_n), .trig(blk_trig[K]), .opp(blk_opp[K]),
          .type_en(blk_type_en[K*N_TYPE +: N_TYPE]),
          .ins(ins_pulse[K*N_TYPE +: N_TYPE]),
          .armed_q(armed_vec[K]), .rise(rise_vec[K]), .fire(fire_vec[K])
        );
      end
    end
  endgenerate
endmodule

// File: rtl/eit_chk.sv
module eit_chk #(
  parameter int NB = 6,
  parameter int NT = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic [NB-1:0]    opp,
  input logic [NB*NT-1:0] en,
  input logic [NB*NT-1:0] ins,
  input logic [NB-1:0]    armed,
  input logic [NB-1:0]    rise,
  input logic [NB-1:0]    fire
);
  genvar g;
  generate
    for (g = 0; g < NB; g++) begin : g_c
      p_pulse_with_opp_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (|ins[g*NT +: NT]) |-> opp[g]);
      p_enable_gate_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (|ins[g*NT +: NT]) |-> ((ins[g*NT +: NT] & ~en[g*NT +: NT]) == '0));
      p_quiet_unarmed_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !armed[g] |-> (ins[g*NT +: NT] == '0));
      p_rise_arms_r10: assert property (@(posedge clk) disable iff (!rst_n)
        rise[g] |=> armed[g]);
      p_fire_consumes_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (fire[g] && !rise[g]) |=> !armed[g]);
      p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (!rise[g] && !opp[g]) |=> $stable(armed[g]));
    end
  endgenerate
endmodule

bind err_inject_trig eit_chk #(.NB(NB), .NT(N_TYPE)) u_chk (
  .clk(clk), .rst_n(rst_n), .opp(blk_opp), .en(blk_type_en), .ins(ins_pulse),
  .armed(armed_vec), .rise(rise_vec), .fire(fire_vec)
);

// File: tb/sim_err_inject_trig.sv
module sim_err_inject_trig;
  localparam int NP = 2, NBK = 3, NT = 4;
  localparam int NK = NP * NBK;
  localparam int NI = NK * NT;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_n, pin, g_sel, g_bit;
  logic [NP-1:0] p_sel, p_bit;
  logic [NK-1:0] b_sel, b_bit, opp;
  logic [NI-1:0] en, ins;

  int checks = 0, errs = 0;
  bit done = 0;

  err_inject_trig u0 (
    .clk(clk), .rst_n(rst_n), .ext_trig_pin(pin), .glb_use_pin(g_sel),
    .glb_reg_trig(g_bit), .port_use_glb(p_sel), .port_reg_trig(p_bit),
    .blk_use_port(b_sel), .blk_reg_trig(b_bit), .blk_type_en(en),
    .blk_opp(opp), .ins_pulse(ins)
  );

  // Expected pulse vector: enables of block k placed at bits k*NT.
  function automatic logic [NI-1:0] slot(input int k, input logic [NT-1:0] v);
    logic [NI-1:0] r = '0;
    r[k*NT +: NT] = v;
    return r;
  endfunction

  task automatic step();
    @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [NI-1:0] exp);
    #1;
    checks++;
    if (ins !== exp) begin
      errs++;
      $display("FAIL %s: ins=%h expected=%h", req, ins, exp);
    end
  endtask

  task automatic t_reset();  // R1
    opp = '1;
    chk("R1", '0);
    step(); opp = '0;
  endtask

  task automatic t_block();  // R2, R8
    step(); p_bit = '1; g_bit = 1'b1; pin = 1'b1;
    step(); step(); step();
    opp[0] = 1'b1; chk("R2 ignored", '0);
    step(); opp = '0; p_bit = '0; g_bit = 1'b0; pin = 1'b0; b_bit[0] = 1'b1;
    step(); opp[0] = 1'b1; chk("R2", slot(0, en[0 +: NT]));
    step(); chk("R8 single cycle", '0);
    opp = '0; b_bit[0] = 1'b0;
    step(); step(); step();
  endtask

  task automatic t_port();  // R3
    b_sel[1] = 1'b1; p_sel[0] = 1'b0;
    step(); b_bit[1] = 1'b1; g_bit = 1'b1;
    step(); opp[1] = 1'b1; chk("R3 ignored", '0);
    step(); opp = '0; b_bit[1] = 1'b0; g_bit = 1'b0; p_bit[0] = 1'b1;
    step(); opp[1] = 1'b1; chk("R3", slot(1, en[1*NT +: NT]));
    step(); opp = '0; p_bit[0] = 1'b0;
    step(); b_sel[1] = 1'b0;
    step();
  endtask

  task automatic t_glob();  // R4
    b_sel[3] = 1'b1; p_sel[1] = 1'b1; g_sel = 1'b0;
    step(); p_bit[1] = 1'b1;
    step(); opp[3] = 1'b1; chk("R4 ignored", '0);
    step(); opp = '0; p_bit[1] = 1'b0; g_bit = 1'b1;
    step(); opp[3] = 1'b1; chk("R4", slot(3, en[3*NT +: NT]));
    step(); opp = '0; g_bit = 1'b0;
    step();
  endtask

  task automatic t_pin();  // R5
    g_sel = 1'b1;
    step(); pin = 1'b1;
    @(posedge clk); @(posedge clk);
    step(); opp[3] = 1'b1; chk("R5 early", '0);
    step(); chk("R5", slot(3, en[3*NT +: NT]));
    step(); opp = '0; pin = 1'b0;
    step(); step(); step();
    g_sel = 1'b0; p_sel[1] = 1'b0; b_sel[3] = 1'b0;
    step();
  endtask

  task automatic t_multi();  // R6
    step(); b_bit[0] = 1'b1;
    step(); b_bit[0] = 1'b0;
    step(); b_bit[0] = 1'b1;
    step(); b_bit[0] = 1'b0;
    step(); opp[0] = 1'b1; chk("R6 one", slot(0, en[0 +: NT]));
    step(); chk("R6 no second", '0);
    opp = '0;
    step();
  endtask

  task automatic t_enable();  // R7, R9
    en[4*NT +: NT] = 4'b0100; en[5*NT +: NT] = '0;
    step(); b_bit[4] = 1'b1; b_bit[5] = 1'b1;
    step(); opp[4] = 1'b1; opp[5] = 1'b1;
    chk("R7", slot(4, 4'b0100));
    step(); opp = '0; en[5*NT +: NT] = '1;
    step(); opp[5] = 1'b1; chk("R9", '0);
    step(); opp = '0; b_bit[4] = 1'b0; b_bit[5] = 1'b0;
    step();
  endtask

  task automatic t_rearm();  // R10, R11
    step(); b_bit[2] = 1'b1;
    step(); b_bit[2] = 1'b0;
    step(); b_bit[2] = 1'b1; opp[2] = 1'b1;
    chk("R10 first", slot(2, en[2*NT +: NT]));
    step(); chk("R10 rearmed", slot(2, en[2*NT +: NT]));
    step(); chk("R11 held high", '0);
    opp = '0;
    step(); step(); opp[2] = 1'b1; chk("R11 still quiet", '0);
    step(); opp = '0; b_bit[2] = 1'b0;
    step();
  endtask

  task automatic t_indep();  // R12
    step(); b_bit[0] = 1'b1; b_bit[2] = 1'b1;
    step(); opp[2] = 1'b1; chk("R12 other", slot(2, en[2*NT +: NT]));
    step(); opp = '0;
    step(); opp[0] = 1'b1; chk("R12 kept", slot(0, en[0 +: NT]));
    step(); opp = '0; b_bit[0] = 1'b0; b_bit[2] = 1'b0;
    step();
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      errs++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errs);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; pin = 1'b0; g_sel = 1'b0; g_bit = 1'b0;
    p_sel = '0; p_bit = '0; b_sel = '0; b_bit = '0; opp = '0; en = '1;
    step(); step(); step();
    rst_n = 1'b1;
    step();
    t_reset();
    t_block();
    t_port();
    t_glob();
    t_pin();
    t_multi();
    t_enable();
    t_rearm();
    t_indep();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errs);
      $finish;
    end
  end
endmodule